// File: doc/BRIEF.md
# Command CRC Checker with Write Lockout

This block guards the command path of a byte-wide serial register port. Each command frame is a payload of two or three bytes (operation, address, optional data). When checking is switched on, one CRC-8 byte follows the payload. The block runs the payload through a CRC-8 engine and compares the result with the trailing byte. It forwards a frame that matches as a one-cycle command strobe carrying the decoded fields. It discards a frame that does not match and raises a sticky error flag.

While the flag is up, write commands are refused unless they target the status or general-config address. Reads and other non-write commands with a good CRC are still forwarded. The host clears the flag by writing a one to bit 0 of the status address. A second, independent CRC-8 engine produces the check byte that the response path appends after each response payload of one to three bytes.

Top module: `cmd_crc_top`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), seeded with 0xFF at the first byte, processed MSB first. A single response byte 0x00 gives 0xF3.
- R2: A command frame's bytes arrive on `inByte` with `inValid`. `inLast` marks the final byte. With `crcEnable` high, that final byte is the CRC of all bytes before it. Byte 0 is the operation, byte 1 the address and byte 2 the data.
- R3: A frame whose CRC matches raises `cmdFire` for one cycle, in the cycle after its final byte. In that cycle `cmdOp`, `cmdAddr` and `cmdData` carry the fields, and `cmdData` is 0 for a two-byte payload.
- R4: A frame whose CRC does not match gives no `cmdFire`. `errFlag` is 1 from the cycle after its final byte and stays 1 across later frames.
- R5: While `errFlag` is 1, a write (operation 0x08) to any address other than 0x00 or 0x01 gives no `cmdFire`, even with a good CRC.
- R6: While `errFlag` is 1, non-write commands and writes to 0x00 or 0x01 that carry a good CRC are still forwarded.
- R7: A forwarded write to address 0x00 with data bit 0 set clears `errFlag` in the cycle after its final byte. The same write with bit 0 clear leaves the flag unchanged.
- R8: With `crcEnable` low, frames carry no CRC byte, every frame is forwarded, and `errFlag` is never set.
- R9: In the cycle after a response byte marked `rspLast`, `rspCrcValid` is 1 for one cycle. In that cycle `rspCrc` holds the CRC over exactly that response's bytes.
- R10: The command and response engines are independent. A command frame and a response may end in the same cycle and both give correct results.
- R11: During and after reset, `errFlag`, `cmdFire` and `rspCrcValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| crcEnable | input | 1 | CRC checking on; taken from the general-config register |
| inValid | input | 1 | A command byte is present |
| inByte | input | 8 | Command byte |
| inLast | input | 1 | Final byte of the command frame |
| rspValid | input | 1 | A response byte is present |
| rspByte | input | 8 | Response byte |
| rspLast | input | 1 | Final byte of the response payload |
| cmdFire | output | 1 | Accepted command strobe |
| cmdOp | output | 8 | Operation of the accepted command |
| cmdAddr | output | 8 | Address of the accepted command |
| cmdData | output | 8 | Data of the accepted command |
| errFlag | output | 1 | Sticky input-CRC error flag |
| rspCrcValid | output | 1 | Response CRC ready strobe |
| rspCrc | output | 8 | CRC over the last response payload |

## Verification
Two things can happen in the same cycle: the response engine finishing a payload, and the command side judging a frame's CRC byte (setting the flag or forwarding). The bench provokes this by driving a response's last byte in the very cycle that a command with a corrupted CRC byte ends. It then checks in the following cycle that the flag is set, that no command strobe appears, and that the response CRC matches the value the bench computed itself. Lockout and clearing are also driven in sequence, so that a flag set, a refused write, a protected write and a clearing write follow one another frame after frame.

// File: rtl/cmd_crc_pkg.sv
package cmd_crc_pkg;
  localparam int BYTE_W      = 8;
  localparam int MAX_PAYLOAD = 3;
  localparam int IDX_W       = $clog2(MAX_PAYLOAD + 1);
  localparam int ERR_CLR_BIT = 0;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CRC_POLY    = 8'h07;
  localparam byte_t CRC_SEED    = 8'hFF;
  localparam byte_t OP_WRITE    = 8'h08;
  localparam byte_t ADDR_STATUS = 8'h00;
  localparam byte_t ADDR_GENCFG = 8'h01;

  // strobes from control to datapath
  typedef struct packed {
    logic             cmdStep;
    logic             cmdFirst;
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
    logic             loadOut;
    logic             rspStep;
    logic             rspFirst;
  } ctl_t;

  // one byte through the CRC, most significant bit first
  function automatic byte_t crc8Next(input byte_t crcIn, input byte_t data);
    byte_t c;
    c = crcIn;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[BYTE_W-1] ^ data[i]) c = (c << 1) ^ CRC_POLY;
      else                       c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/cmd_crc_datapath.sv
module cmd_crc_datapath
  import cmd_crc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  ctl_t  ctl,
  input  byte_t inByte,
  input  byte_t rspByte,
  output logic  crcMatch,
  output byte_t frameOp,
  output byte_t frameAddr,
  output logic  frameClr,
  output byte_t cmdOp,
  output byte_t cmdAddr,
  output byte_t cmdData,
  output byte_t rspCrc
);
  byte_t cmdCrcQ, opQ, addrQ, dataQ, frameData;
  logic  firstCap;

  assign firstCap = ctl.capEn && (ctl.capIdx == '0);

  // field view that includes the byte arriving this cycle
  always_comb begin
    frameOp   = opQ;
    frameAddr = addrQ;
    frameData = dataQ;
    if (firstCap) begin
      frameOp   = inByte;
      frameAddr = '0;
      frameData = '0;
    end else if (ctl.capEn && ctl.capIdx == IDX_W'(1)) begin
      frameAddr = inByte;
    end else if (ctl.capEn && ctl.capIdx == IDX_W'(2)) begin
      frameData = inByte;
    end
  end

  assign frameClr = frameData[ERR_CLR_BIT];
  assign crcMatch = (cmdCrcQ == inByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCrcQ <= CRC_SEED;
      opQ     <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      cmdOp   <= '0;
      cmdAddr <= '0;
      cmdData <= '0;
      rspCrc  <= CRC_SEED;
    end else begin
      if (ctl.cmdStep)
        cmdCrcQ <= crc8Next(ctl.cmdFirst ? CRC_SEED : cmdCrcQ, inByte);
      if (ctl.capEn) begin
        opQ   <= frameOp;
        addrQ <= frameAddr;
        dataQ <= frameData;
      end
      if (ctl.loadOut) begin
        cmdOp   <= frameOp;
        cmdAddr <= frameAddr;
        cmdData <= frameData;
      end
      if (ctl.rspStep)
        rspCrc <= crc8Next(ctl.rspFirst ? CRC_SEED : rspCrc, rspByte);
    end
  end

  // R3: a fresh first byte wipes the stale address and data of the last frame
  p_first_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    firstCap |=> (addrQ == '0) && (dataQ == '0));
endmodule

// File: rtl/cmd_crc_control.sv
module cmd_crc_control
  import cmd_crc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  crcEnable,
  input  logic  inValid,
  input  logic  inLast,
  input  logic  rspValid,
  input  logic  rspLast,
  input  logic  crcMatch,
  input  byte_t frameOp,
  input  byte_t frameAddr,
  input  logic  frameClr,
  output ctl_t  ctl,
  output logic  cmdFire,
  output logic  errFlag,
  output logic  rspCrcValid
);
  logic [IDX_W-1:0] byteIdx;
  logic rspMid;
  logic frameEnd, isCrcByte, isWrite, protAddr, crcOk, writeOk, fireNow, errSet, errClr;

  assign frameEnd  = inValid && inLast;
  assign isCrcByte = frameEnd && crcEnable;
  assign isWrite   = (frameOp == OP_WRITE);
  assign protAddr  = (frameAddr == ADDR_STATUS) || (frameAddr == ADDR_GENCFG);
  assign crcOk     = !crcEnable || crcMatch;
  assign writeOk   = !isWrite || !errFlag || protAddr || !crcEnable;
  assign fireNow   = frameEnd && crcOk && writeOk;
  assign errSet    = isCrcByte && !crcMatch;
  assign errClr    = fireNow && isWrite && (frameAddr == ADDR_STATUS) && frameClr;

  always_comb begin
    ctl.cmdStep  = inValid && !isCrcByte;
    ctl.cmdFirst = (byteIdx == '0);
    ctl.capEn    = ctl.cmdStep && (byteIdx < IDX_W'(MAX_PAYLOAD));
    ctl.capIdx   = byteIdx;
    ctl.loadOut  = fireNow;
    ctl.rspStep  = rspValid;
    ctl.rspFirst = !rspMid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx     <= '0;
      rspMid      <= 1'b0;
      errFlag     <= 1'b0;
      cmdFire     <= 1'b0;
      rspCrcValid <= 1'b0;
    end else begin
      if (inValid) begin
        if (inLast)                  byteIdx <= '0;
        else if (byteIdx != '1)      byteIdx <= byteIdx + 1'b1;
      end
      if (rspValid) rspMid <= !rspLast;
      if (errSet)      errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
      cmdFire     <= fireNow;
      rspCrcValid <= rspValid && rspLast;
    end
  end

  // R4: the flag only rises after a checked frame whose CRC failed
  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(inValid && inLast && crcEnable && !crcMatch));
  // R4: a failed frame is never forwarded and leaves the flag set
  p_bad_dropped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast && crcEnable && !crcMatch) |=> (!cmdFire && errFlag));
  // R5: locked-out writes produce no strobe
  p_lockout_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast && crcEnable && errFlag && frameOp == OP_WRITE &&
     frameAddr > ADDR_GENCFG) |=> !cmdFire);
  // R7: the flag falls only together with an accepted command
  p_clear_by_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> cmdFire);
  // R8: with checking off the flag cannot rise
  p_off_no_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast && !crcEnable) |=> !$rose(errFlag));
  // R9: the response strobe follows a final response byte
  p_rsp_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspCrcValid |-> $past(rspValid && rspLast));
endmodule

// File: rtl/cmd_crc_top.sv
module cmd_crc_top
  import cmd_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       crcEnable,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       inLast,
  input  logic       rspValid,
  input  logic [7:0] rspByte,
  input  logic       rspLast,
  output logic       cmdFire,
  output logic [7:0] cmdOp,
  output logic [7:0] cmdAddr,
  output logic [7:0] cmdData,
  output logic       errFlag,
  output logic       rspCrcValid,
  output logic [7:0] rspCrc
);
  ctl_t  ctl;
  logic  crcMatch, frameClr;
  byte_t frameOp, frameAddr;

  cmd_crc_control u_ctrl (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable),
    .inValid(inValid), .inLast(inLast),
    .rspValid(rspValid), .rspLast(rspLast),
    .crcMatch(crcMatch), .frameOp(frameOp), .frameAddr(frameAddr), .frameClr(frameClr),
    .ctl(ctl), .cmdFire(cmdFire), .errFlag(errFlag), .rspCrcValid(rspCrcValid)
  );

  cmd_crc_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inByte(inByte), .rspByte(rspByte),
    .crcMatch(crcMatch), .frameOp(frameOp), .frameAddr(frameAddr), .frameClr(frameClr),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .rspCrc(rspCrc)
  );
endmodule

// File: tb/cmd_crc_top_tb.sv
module cmd_crc_top_tb;
  logic clk = 1'b0;
  logic rstN, crcEnable, inValid, inLast, rspValid, rspLast;
  logic [7:0] inByte, rspByte;
  logic cmdFire, errFlag, rspCrcValid;
  logic [7:0] cmdOp, cmdAddr, cmdData, rspCrc;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cmd_crc_top u_dut (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable),
    .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .rspValid(rspValid), .rspByte(rspByte), .rspLast(rspLast),
    .cmdFire(cmdFire), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .errFlag(errFlag), .rspCrcValid(rspCrcValid), .rspCrc(rspCrc)
  );

  // {tag[3:0], len[1:0], op, addr, data, corrupt, expFire, expErr}
  localparam logic [32:0] VEC [10] = '{
    {4'd3, 2'd2, 8'h10, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0},
    {4'd3, 2'd3, 8'h08, 8'h05, 8'hAA, 1'b0, 1'b1, 1'b0},
    {4'd4, 2'd3, 8'h08, 8'h05, 8'hAA, 1'b1, 1'b0, 1'b1},
    {4'd5, 2'd3, 8'h08, 8'h05, 8'h55, 1'b0, 1'b0, 1'b1},
    {4'd6, 2'd2, 8'h10, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1},
    {4'd6, 2'd3, 8'h08, 8'h01, 8'h33, 1'b0, 1'b1, 1'b1},
    {4'd7, 2'd3, 8'h08, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    {4'd4, 2'd2, 8'h10, 8'h07, 8'h00, 1'b1, 1'b0, 1'b1},
    {4'd7, 2'd3, 8'h08, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0},
    {4'd5, 2'd3, 8'h08, 8'h05, 8'h55, 1'b0, 1'b1, 1'b0}
  };

  function automatic logic [7:0] refCrc(input logic [7:0] b0, b1, b2, input int n);
    logic [7:0] c;
    logic [7:0] seq [3];
    seq[0] = b0; seq[1] = b1; seq[2] = b2;
    c = 8'hFF;
    for (int k = 0; k < n; k++)
      for (int j = 7; j >= 0; j--) begin
        logic fb;
        fb = c[7] ^ seq[k][j];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input int n, input logic [7:0] b0, b1, b2,
                         input bit corrupt, input bit useCrc, output bit fired);
    logic [7:0] seq [4];
    int len;
    seq[0] = b0; seq[1] = b1; seq[2] = b2;
    seq[n] = refCrc(b0, b1, b2, n) ^ (corrupt ? 8'h01 : 8'h00);
    len = n + (useCrc ? 1 : 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inByte = seq[i]; inLast = (i == len - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inByte = 8'h00;
    fired = cmdFire;
  endtask

  task automatic sendRsp(input int n, input logic [7:0] b0, b1, b2, input string req);
    logic [7:0] seq [3];
    seq[0] = b0; seq[1] = b1; seq[2] = b2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rspValid = 1'b1; rspByte = seq[i]; rspLast = (i == n - 1);
    end
    @(negedge clk);
    rspValid = 1'b0; rspLast = 1'b0;
    chk(rspCrcValid == 1'b1, req, rspCrcValid, 1);
    chk(rspCrc == refCrc(b0, b1, b2, n), req, rspCrc, refCrc(b0, b1, b2, n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit fired;
    string tag;
    rstN = 1'b0; crcEnable = 1'b1;
    inValid = 1'b0; inLast = 1'b0; inByte = 8'h00;
    rspValid = 1'b0; rspLast = 1'b0; rspByte = 8'h00;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(errFlag == 1'b0, "R11 errFlag", errFlag, 0);
    chk(cmdFire == 1'b0, "R11 cmdFire", cmdFire, 0);
    chk(rspCrcValid == 1'b0, "R11 rspCrcValid", rspCrcValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(errFlag == 1'b0 && cmdFire == 1'b0, "R11 after release", errFlag, 0);

    // R2 R3 R4 R5 R6 R7: vector walk
    for (int v = 0; v < 10; v++) begin
      logic [32:0] e;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[32:29], v);
      sendCmd(int'(e[28:27]), e[26:19], e[18:11], e[10:3], e[2], 1'b1, fired);
      chk(fired == e[1], tag, fired, e[1]);
      if (e[1]) begin
        chk(cmdOp == e[26:19] && cmdAddr == e[18:11] && cmdData == e[10:3],
            {tag, " fields"}, {cmdOp, cmdAddr, cmdData}, e[26:3]);
      end
      chk(errFlag == e[0], {tag, " flag"}, errFlag, e[0]);
    end

    // R1: fixed anchor value
    sendRsp(1, 8'h00, 8'h00, 8'h00, "R1 anchor");
    chk(rspCrc == 8'hF3, "R1 literal", rspCrc, 8'hF3);
    // R9: response lengths one to three
    sendRsp(1, 8'h5A, 8'h00, 8'h00, "R9 one byte");
    sendRsp(2, 8'h12, 8'h34, 8'h00, "R9 two bytes");
    sendRsp(3, 8'hDE, 8'hAD, 8'hBE, "R9 three bytes");
    @(negedge clk);
    chk(rspCrcValid == 1'b0, "R9 strobe single cycle", rspCrcValid, 0);

    // R8: checking off, no CRC byte, all forwarded
    crcEnable = 1'b0;
    sendCmd(3, 8'h08, 8'h09, 8'h77, 1'b0, 1'b0, fired);
    chk(fired == 1'b1 && cmdAddr == 8'h09 && cmdData == 8'h77, "R8 plain write", cmdData, 8'h77);
    sendCmd(2, 8'h10, 8'h04, 8'h00, 1'b0, 1'b0, fired);
    chk(fired == 1'b1 && cmdData == 8'h00, "R8 plain read", fired, 1);
    chk(errFlag == 1'b0, "R8 flag stays low", errFlag, 0);

    // R10: failed command and response end in the same cycle
    crcEnable = 1'b1;
    @(negedge clk);
    inValid = 1'b1; inLast = 1'b0; inByte = 8'h10;
    @(negedge clk);
    inByte = 8'h06;
    @(negedge clk);
    inLast = 1'b1; inByte = refCrc(8'h10, 8'h06, 8'h00, 2) ^ 8'h80;
    rspValid = 1'b1; rspLast = 1'b1; rspByte = 8'h3C;
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; rspValid = 1'b0; rspLast = 1'b0;
    chk(errFlag == 1'b1, "R10 flag set", errFlag, 1);
    chk(cmdFire == 1'b0, "R10 no strobe", cmdFire, 0);
    chk(rspCrcValid == 1'b1 && rspCrc == refCrc(8'h3C, 8'h00, 8'h00, 1),
        "R10 response crc", rspCrc, refCrc(8'h3C, 8'h00, 8'h00, 1));

    // R5: locked write refused, R7: clear, then allowed
    sendCmd(3, 8'h08, 8'h20, 8'h11, 1'b0, 1'b1, fired);
    chk(fired == 1'b0 && errFlag == 1'b1, "R5 refused write", fired, 0);
    sendCmd(3, 8'h08, 8'h00, 8'h01, 1'b0, 1'b1, fired);
    chk(fired == 1'b1 && errFlag == 1'b0, "R7 clear", errFlag, 0);
    sendCmd(3, 8'h08, 8'h20, 8'h11, 1'b0, 1'b1, fired);
    chk(fired == 1'b1 && cmdAddr == 8'h20, "R5 write after clear", cmdAddr, 8'h20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule